// File: doc/BRIEF.md
# Complex-Instruction Micro-Op Sequencer

This block sits between an instruction decoder and the execution back end. It takes one decoded complex instruction at a time over a valid/ready handshake. It then issues that instruction's micro-op sequence on a second valid/ready channel, one micro-op per accepted cycle. Each micro-op carries a kind code, a destination register specifier, a source register specifier and a flag that marks the final micro-op of the sequence.

Register-memory arithmetic is split into a load into a temporary register, the operation itself and, for a memory destination, a store back. Scaled addressing first computes the address into a second temporary register. Calls, returns and pushes expand into fixed stack sequences that read or adjust the stack pointer.

The control is a two-state machine. ST_IDLE accepts an instruction (transition *capture*, to ST_EMIT). ST_EMIT presents the micro-op at the current step. On a handshake it either advances the step (*advance*) or, at the final micro-op, goes back to ST_IDLE (*retire*). It can instead take the next waiting instruction in that same cycle and stay in ST_EMIT with the step cleared (*chain*). When the output is not ready it stays put (*stall*).

Top module: `uop_cracker`

## Requirements
- R1: After reset the block offers no micro-op (out_valid low) and is ready for an instruction (in_ready high).
- R2: Class codes 0 (ALU), 1 (compare) and 2 (branch) with no memory flag set emit one micro-op with the last flag set. Its kind is 1, 2 or 3 respectively, and both its destination and source are the register operand.
- R3: An ALU instruction with only the memory-source flag emits two micro-ops: a load (kind 4) with destination the temporary register TMP_REG and source the address register, then the ALU op (kind 1) with destination the register operand and source TMP_REG.
- R4: An ALU instruction with the memory-destination flag emits three micro-ops: a load (kind 4, destination TMP_REG, source the address register), an ALU op (kind 1, destination TMP_REG, source the register operand) and a store (kind 5, destination the address register, source TMP_REG). The destination flag takes precedence when both memory flags are set.
- R5: When an ALU instruction has a memory flag and the scaled flag, an address micro-op (kind 6, destination ADR_REG, source the base register) comes first, and ADR_REG serves as the address register in the following micro-ops. Otherwise the base register is the address register.
- R6: Class 3 (call) emits four micro-ops in this order: program-counter read (kind 7, TMP_REG, 0), store (kind 5, SP_REG, TMP_REG), stack decrement by 4 (kind 8, SP_REG, SP_REG), unconditional jump (kind 9, 0, register operand).
- R7: Class 4 (return) emits three micro-ops in this order: stack increment by 4 (kind 11, SP_REG, SP_REG), load (kind 4, TMP_REG, SP_REG), register jump (kind 10, 0, TMP_REG).
- R8: Class 5 (push) emits a store at stack pointer minus 4 (kind 5, SP_REG, register operand), then a stack decrement by 4 (kind 8, SP_REG, SP_REG).
- R9: Exactly one micro-op is consumed per output handshake, and only the final micro-op of a sequence carries the last flag.
- R10: While out_valid is high and out_ready is low, out_valid and the micro-op fields hold their values into the next cycle.
- R11: in_ready is high only in the idle state or in the cycle in which the final micro-op is handed off. An instruction offered in that cycle is taken at once, with no idle cycle between the sequences.
- R12: The memory and scaled flags are ignored for every class other than ALU. Class codes 6 and 7 emit a single no-op micro-op (kind 0) whose destination and source are the register operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_cls | input | 3 | Instruction class code |
| in_reg | input | REG_W | Register operand |
| in_base | input | REG_W | Base register of the memory operand |
| in_mem_src | input | 1 | Source operand is in memory |
| in_mem_dst | input | 1 | Destination operand is in memory |
| in_scaled | input | 1 | Memory operand uses scaled addressing |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 4 | Micro-op kind code |
| out_dst | output | REG_W | Destination register specifier |
| out_src | output | REG_W | Source register specifier |
| out_last | output | 1 | Final micro-op of the sequence |

## Verification
The handoff of a sequence's final micro-op and the capture of the next instruction can fall in the same cycle. That is the *chain* transition. The bench provokes it by offering instructions back to back while out_ready runs both always high and in stall patterns. It judges the result in two ways: in_ready must be high exactly when the last micro-op leaves with in_valid waiting, and the scoreboard must see the next sequence follow with no missing or repeated micro-op. Stall patterns that drop out_ready on the last micro-op check that no capture happens while it is held.

// File: rtl/uop_pkg.sv
package uop_pkg;

    localparam int unsigned MAX_UOPS = 4;

    typedef enum logic [2:0] {
        CLS_ALU  = 3'd0,
        CLS_CMP  = 3'd1,
        CLS_BR   = 3'd2,
        CLS_CALL = 3'd3,
        CLS_RET  = 3'd4,
        CLS_PUSH = 3'd5,
        CLS_RSV6 = 3'd6,
        CLS_RSV7 = 3'd7
    } instr_cls_e;

    typedef enum logic [3:0] {
        UK_NOP   = 4'd0,
        UK_ALU   = 4'd1,
        UK_CMP   = 4'd2,
        UK_BR    = 4'd3,
        UK_LOAD  = 4'd4,
        UK_STORE = 4'd5,
        UK_AGEN  = 4'd6,
        UK_RDPC  = 4'd7,
        UK_SPDEC = 4'd8,
        UK_JMP   = 4'd9,
        UK_JMPR  = 4'd10,
        UK_SPINC = 4'd11
    } uop_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/uop_expand.sv
module uop_expand
    import uop_pkg::*;
#(
    parameter int unsigned REG_W   = 4,
    parameter int unsigned SP_REG  = 4,
    parameter int unsigned ADR_REG = 14,
    parameter int unsigned TMP_REG = 15,
    parameter int unsigned STEP_W  = $clog2(MAX_UOPS)
) (
    input  instr_cls_e        cls,
    input  logic [REG_W-1:0]  reg_op,
    input  logic [REG_W-1:0]  base,
    input  logic              mem_src,
    input  logic              mem_dst,
    input  logic              scaled,
    input  logic [STEP_W-1:0] step,
    output uop_kind_e         kind,
    output logic [REG_W-1:0]  dst,
    output logic [REG_W-1:0]  src,
    output logic              last
);
    localparam logic [REG_W-1:0] SP  = REG_W'(SP_REG);
    localparam logic [REG_W-1:0] ADR = REG_W'(ADR_REG);
    localparam logic [REG_W-1:0] TMP = REG_W'(TMP_REG);
    localparam logic [REG_W-1:0] R0  = '0;

    uop_kind_e        k_a [MAX_UOPS];
    logic [REG_W-1:0] d_a [MAX_UOPS];
    logic [REG_W-1:0] s_a [MAX_UOPS];
    logic [STEP_W:0]  len;
    logic [REG_W-1:0] addr;

    // Builds the whole sequence for the held instruction; the step picks one entry.
    always_comb begin
        for (int i = 0; i < MAX_UOPS; i++) begin
            k_a[i] = UK_NOP;
            d_a[i] = R0;
            s_a[i] = R0;
        end
        len  = '0;
        addr = (scaled && (mem_src || mem_dst)) ? ADR : base;
        unique case (cls)
            CLS_ALU: begin
                if (mem_src || mem_dst) begin
                    if (scaled) begin
                        k_a[len[STEP_W-1:0]] = UK_AGEN;
                        d_a[len[STEP_W-1:0]] = ADR;
                        s_a[len[STEP_W-1:0]] = base;
                        len = len + 1'b1;
                    end
                    k_a[len[STEP_W-1:0]] = UK_LOAD;
                    d_a[len[STEP_W-1:0]] = TMP;
                    s_a[len[STEP_W-1:0]] = addr;
                    len = len + 1'b1;
                    if (mem_dst) begin
                        k_a[len[STEP_W-1:0]] = UK_ALU;
                        d_a[len[STEP_W-1:0]] = TMP;
                        s_a[len[STEP_W-1:0]] = reg_op;
                        len = len + 1'b1;
                        k_a[len[STEP_W-1:0]] = UK_STORE;
                        d_a[len[STEP_W-1:0]] = addr;
                        s_a[len[STEP_W-1:0]] = TMP;
                        len = len + 1'b1;
                    end else begin
                        k_a[len[STEP_W-1:0]] = UK_ALU;
                        d_a[len[STEP_W-1:0]] = reg_op;
                        s_a[len[STEP_W-1:0]] = TMP;
                        len = len + 1'b1;
                    end
                end else begin
                    k_a[0] = UK_ALU; d_a[0] = reg_op; s_a[0] = reg_op;
                    len = 1;
                end
            end
            CLS_CMP: begin
                k_a[0] = UK_CMP; d_a[0] = reg_op; s_a[0] = reg_op;
                len = 1;
            end
            CLS_BR: begin
                k_a[0] = UK_BR; d_a[0] = reg_op; s_a[0] = reg_op;
                len = 1;
            end
            CLS_CALL: begin
                k_a[0] = UK_RDPC;  d_a[0] = TMP; s_a[0] = R0;
                k_a[1] = UK_STORE; d_a[1] = SP;  s_a[1] = TMP;
                k_a[2] = UK_SPDEC; d_a[2] = SP;  s_a[2] = SP;
                k_a[3] = UK_JMP;   d_a[3] = R0;  s_a[3] = reg_op;
                len = 4;
            end
            CLS_RET: begin
                k_a[0] = UK_SPINC; d_a[0] = SP;  s_a[0] = SP;
                k_a[1] = UK_LOAD;  d_a[1] = TMP; s_a[1] = SP;
                k_a[2] = UK_JMPR;  d_a[2] = R0;  s_a[2] = TMP;
                len = 3;
            end
            CLS_PUSH: begin
                k_a[0] = UK_STORE; d_a[0] = SP; s_a[0] = reg_op;
                k_a[1] = UK_SPDEC; d_a[1] = SP; s_a[1] = SP;
                len = 2;
            end
            CLS_RSV6, CLS_RSV7: begin
                k_a[0] = UK_NOP; d_a[0] = reg_op; s_a[0] = reg_op;
                len = 1;
            end
        endcase
    end

    always_comb begin
        kind = k_a[step];
        dst  = d_a[step];
        src  = s_a[step];
        last = ({1'b0, step} == (len - 1'b1));
    end

endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl
    import uop_pkg::*;
#(
    parameter int unsigned STEP_W = $clog2(MAX_UOPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic              seq_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic              load_en,
    output logic [STEP_W-1:0] step
);
    seq_state_e        state, state_nx;
    logic [STEP_W-1:0] step_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        step_nx   = step;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_en   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin          // capture
                    load_en  = 1'b1;
                    step_nx  = '0;
                    state_nx = ST_EMIT;
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (seq_last) begin
                        in_ready = 1'b1;
                        step_nx  = '0;
                        if (in_valid) begin  // chain
                            load_en = 1'b1;
                        end else begin       // retire
                            state_nx = ST_IDLE;
                        end
                    end else begin           // advance
                        step_nx = step + 1'b1;
                    end
                end                          // stall otherwise
            end
        endcase
    end

    assert_step_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(step)));

    assert_no_midseq_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || (seq_last && out_ready)));

    assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !seq_last) |=> (out_valid && step == $past(step) + 1'b1));

endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
    import uop_pkg::*;
#(
    parameter int unsigned REG_W   = 4,
    parameter int unsigned SP_REG  = 4,
    parameter int unsigned ADR_REG = 14,
    parameter int unsigned TMP_REG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_cls,
    input  logic [REG_W-1:0] in_reg,
    input  logic [REG_W-1:0] in_base,
    input  logic             in_mem_src,
    input  logic             in_mem_dst,
    input  logic             in_scaled,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_kind,
    output logic [REG_W-1:0] out_dst,
    output logic [REG_W-1:0] out_src,
    output logic             out_last
);
    localparam int unsigned STEP_W = $clog2(MAX_UOPS);

    instr_cls_e        h_cls;
    logic [REG_W-1:0]  h_reg, h_base;
    logic              h_msrc, h_mdst, h_scaled;
    logic              load_en;
    logic [STEP_W-1:0] step;
    uop_kind_e         kind;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cls    <= CLS_ALU;
            h_reg    <= '0;
            h_base   <= '0;
            h_msrc   <= 1'b0;
            h_mdst   <= 1'b0;
            h_scaled <= 1'b0;
        end else if (load_en) begin
            h_cls    <= instr_cls_e'(in_cls);
            h_reg    <= in_reg;
            h_base   <= in_base;
            h_msrc   <= in_mem_src;
            h_mdst   <= in_mem_dst;
            h_scaled <= in_scaled;
        end
    end

    uop_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .seq_last  (out_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_en   (load_en),
        .step      (step)
    );

    uop_expand #(
        .REG_W   (REG_W),
        .SP_REG  (SP_REG),
        .ADR_REG (ADR_REG),
        .TMP_REG (TMP_REG),
        .STEP_W  (STEP_W)
    ) u_expand (
        .cls     (h_cls),
        .reg_op  (h_reg),
        .base    (h_base),
        .mem_src (h_msrc),
        .mem_dst (h_mdst),
        .scaled  (h_scaled),
        .step    (step),
        .kind    (kind),
        .dst     (out_dst),
        .src     (out_src),
        .last    (out_last)
    );

    assign out_kind = kind;

    assert_uop_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_kind) && $stable(out_dst)
                                       && $stable(out_src) && $stable(out_last)));

    assert_retire_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && !in_valid) |=> !out_valid);

    assert_call_not_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == UK_RDPC) |-> !out_last);

    assert_ret_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_kind == UK_SPINC) |=> (out_valid && out_kind == UK_LOAD));

endmodule

// File: tb/tb_uop_cracker.sv
module tb_uop_cracker;
    localparam int REG_W = 4;
    localparam logic [3:0] SP = 4'd4, ADR = 4'd14, TMP = 4'd15;

    typedef struct { logic [12:0] v; string tag; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [2:0] in_cls = '0;
    logic [3:0] in_reg = '0, in_base = '0;
    logic in_mem_src = 1'b0, in_mem_dst = 1'b0, in_scaled = 1'b0;
    logic out_valid, out_ready = 1'b1, out_last;
    logic [3:0] out_kind, out_dst, out_src;

    int tests = 0, fails = 0, rdy_mode = 0, cyc = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    uop_cracker dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_reg(in_reg), .in_base(in_base),
        .in_mem_src(in_mem_src), .in_mem_dst(in_mem_dst), .in_scaled(in_scaled),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dst(out_dst), .out_src(out_src), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input logic [12:0] act, input logic [12:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void put(input logic [3:0] k, input logic [3:0] d, input logic [3:0] s,
                                input bit l, input string tag);
        exp_t e;
        e.v = {k, d, s, l};
        e.tag = tag;
        q.push_back(e);
    endfunction

    // Expected sequence from the requirement text.
    function automatic void model(input logic [2:0] c, input logic [3:0] r, input logic [3:0] b,
                                  input bit ms, input bit md, input bit sc);
        logic [3:0] a;
        case (c)
            3'd0: begin
                if (ms || md) begin
                    a = sc ? ADR : b;
                    if (sc) put(4'd6, ADR, b, 0, "R5");
                    put(4'd4, TMP, a, 0, md ? "R4" : "R3");
                    if (md) begin
                        put(4'd1, TMP, r, 0, "R4");
                        put(4'd5, a, TMP, 1, "R4");
                    end else put(4'd1, r, TMP, 1, "R3");
                end else put(4'd1, r, r, 1, "R2");
            end
            3'd1: put(4'd2, r, r, 1, "R2");
            3'd2: put(4'd3, r, r, 1, "R2");
            3'd3: begin
                put(4'd7, TMP, 4'd0, 0, "R6");
                put(4'd5, SP, TMP, 0, "R6");
                put(4'd8, SP, SP, 0, "R6");
                put(4'd9, 4'd0, r, 1, "R6");
            end
            3'd4: begin
                put(4'd11, SP, SP, 0, "R7");
                put(4'd4, TMP, SP, 0, "R7");
                put(4'd10, 4'd0, TMP, 1, "R7");
            end
            3'd5: begin
                put(4'd5, SP, r, 0, "R8");
                put(4'd8, SP, SP, 1, "R8");
            end
            default: put(4'd0, r, r, 1, "R12");
        endcase
    endfunction

    // Driver: offers one instruction and returns right after its capture edge.
    task automatic send(input logic [2:0] c, input logic [3:0] r, input logic [3:0] b,
                        input bit ms, input bit md, input bit sc);
        model(c, r, b, ms, md, sc);
        in_cls = c; in_reg = r; in_base = b;
        in_mem_src = ms; in_mem_dst = md; in_scaled = sc;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic run_all();
        send(3'd0, 4'd3, 4'd0, 0, 0, 0);
        send(3'd1, 4'd6, 4'd9, 0, 0, 0);
        send(3'd2, 4'd2, 4'd0, 0, 0, 0);
        send(3'd0, 4'd2, 4'd5, 1, 0, 0);
        send(3'd0, 4'd1, 4'd7, 1, 0, 1);
        send(3'd0, 4'd8, 4'd3, 0, 1, 0);
        send(3'd0, 4'd9, 4'd6, 0, 1, 1);
        send(3'd0, 4'd5, 4'd2, 1, 1, 0);
        send(3'd3, 4'd7, 4'd0, 0, 0, 0);
        send(3'd4, 4'd0, 4'd0, 0, 0, 0);
        send(3'd5, 4'd1, 4'd0, 0, 0, 0);
        send(3'd3, 4'd12, 4'd5, 1, 1, 1);
        send(3'd5, 4'd10, 4'd3, 0, 1, 1);
        send(3'd1, 4'd11, 4'd3, 1, 0, 1);
        send(3'd6, 4'd13, 4'd0, 0, 0, 0);
        send(3'd7, 4'd2, 4'd1, 1, 1, 1);
    endtask

    // Consumer readiness, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = cyc[0];
            endcase
        end
    end

    // Monitor and scoreboard, sampling on the falling edge.
    logic pv = 1'b0, pr = 1'b0;
    logic [12:0] pu = '0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (pv && !pr)
                    check(out_valid && {out_kind, out_dst, out_src, out_last} == pu, "R10",
                          {out_kind, out_dst, out_src, out_last}, pu);
                if (out_valid && !(out_last && out_ready))
                    check(!in_ready, "R11", {12'd0, in_ready}, 13'd0);
                if (out_valid && out_last && out_ready && in_valid)
                    check(in_ready, "R11", {12'd0, in_ready}, 13'd1);
                if (out_valid && out_ready) begin
                    if (q.size() == 0) begin
                        check(0, "R9", {out_kind, out_dst, out_src, out_last}, 13'd0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check({out_kind, out_dst, out_src, out_last} == e.v, e.tag,
                              {out_kind, out_dst, out_src, out_last}, e.v);
                    end
                end
                pv = out_valid;
                pr = out_ready;
                pu = {out_kind, out_dst, out_src, out_last};
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1", {11'd0, out_valid, in_ready}, 13'd1);
        @(posedge clk);
        #1;
        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            run_all();
            while (q.size() != 0) @(posedge clk);
            repeat (2) @(posedge clk);
            #1;
        end
        @(negedge clk);
        check(!out_valid && in_ready, "R9", {11'd0, out_valid, in_ready}, 13'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule